// File: doc/BRIEF.md
# Reconfigurable Self-Test Register

This block is a bank of flip-flops that can take on four jobs at run time. As ordinary pipeline storage it captures a parallel word from the logic that feeds it. As a scan segment it shifts serially, so state can be loaded and read one bit at a time. As a test pattern source it runs as an external-feedback linear feedback shift register whose taps come from a primitive polynomial, so that any non-zero seed leads through every non-zero state before the sequence repeats. As a response compactor it folds the circuit's parallel responses into that same shift register, and the final contents become a signature that tells a good circuit from a faulty one.

A two-bit mode input selects the job on each clock, and all four jobs share one set of flip-flops. A synchronous reset clears the bank. A seed-load input places a fixed non-zero seed in the bank. The serial output always shows the last stage of the chain, so a signature can be shifted out after compaction.

Top module: `bilbo_reg`

## Requirements
- R1: When `rst` is high at a rising clock edge, the register becomes all zeros, whatever the other inputs are.
- R2: When `rst` is low and `seed_load` is high at a rising edge, the register takes the parameter `SEED` (non-zero, default 8'h01), whatever the mode is.
- R3: Mode 2'b00 (capture): the register takes `par_in` at each edge.
- R4: Mode 2'b01 (shift): the register becomes {q[W-2:0], scan_in}, so bit 0 receives the serial input.
- R5: `scan_out` equals register bit W-1 in every mode. Shifting in mode 2'b01 therefore unloads the contents most significant bit first.
- R6: Mode 2'b10 (generate): the register becomes {q[W-2:0], f}. With the default taps, f is the XOR of bits 7, 5, 4 and 3, which gives the polynomial x^8+x^6+x^5+x^4+1.
- R7: In generate mode from a non-zero seed, the default 8-bit register first comes back to the seed after exactly 255 clocks and never holds zero in between.
- R8: In generate mode, a register that holds all zeros is loaded with `SEED` on the next edge, so the generator cannot lock up.
- R9: Mode 2'b11 (compact): the register becomes {q[W-2:0], f} XOR `par_in`, with f as in R6.
- R10: Compacting the same response sequence from the same seed gives the same signature, and a sequence that differs in a single bit of one response gives a different signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| seed_load | input | 1 | Synchronous load of the non-zero seed |
| mode | input | 2 | 00 capture, 01 shift, 10 generate, 11 compact |
| par_in | input | WIDTH | Parallel data or circuit response |
| scan_in | input | 1 | Serial input to bit 0 |
| par_out | output | WIDTH | Register contents |
| scan_out | output | 1 | Last stage of the chain (bit WIDTH-1) |

## Verification
The bench builds the block with the default width of 8 and the default taps, and sets the seed to 8'hA5 so that a reload can be told apart from a plain reset or a one-hot pattern. At this width the full generator cycle of 255 states fits in a short run. The bench therefore checks the exact period and the absence of the zero state directly, rather than inferring them from the polynomial. The small width also keeps a complete signature unload to eight shifts, and it lets a single flipped response bit be traced to a changed signature.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

  typedef enum logic [1:0] {
    BR_CAPTURE  = 2'b00,
    BR_SHIFT    = 2'b01,
    BR_GENERATE = 2'b10,
    BR_COMPACT  = 2'b11
  } bilbo_mode_e;

endpackage

// File: rtl/bilbo_feedback.sv
// Parity of the tapped stages of the register (external feedback).
module bilbo_feedback #(
  parameter int          WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS = 8'b1011_1000
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb
);

  logic [WIDTH:0] chain;

  assign chain[0] = 1'b0;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
      if (TAPS[i]) begin : g_on
        assign chain[i+1] = chain[i] ^ state[i];
      end else begin : g_off
        assign chain[i+1] = chain[i];
      end
    end
  endgenerate

  assign fb = chain[WIDTH];

endmodule

// File: rtl/bilbo_next_state.sv
// Next-state selection for the four behaviours of the shared register.
module bilbo_next_state
  import bilbo_pkg::*;
#(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] SEED  = 8'h01
) (
  input  bilbo_mode_e      mode,
  input  logic [WIDTH-1:0] state,
  input  logic             fb,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  output logic [WIDTH-1:0] next_state
);

  logic [WIDTH-1:0] lfsr_step;
  logic             is_zero;

  assign lfsr_step = {state[WIDTH-2:0], fb};
  assign is_zero   = (state == '0);

  always_comb begin
    unique case (mode)
      BR_CAPTURE:  next_state = par_in;
      BR_SHIFT:    next_state = {state[WIDTH-2:0], scan_in};
      BR_GENERATE: next_state = is_zero ? SEED : lfsr_step;
      BR_COMPACT:  next_state = lfsr_step ^ par_in;
      default:     next_state = state;
    endcase
  end

endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS  = 8'b1011_1000,
  parameter logic [WIDTH-1:0] SEED  = 8'h01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             seed_load,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  output logic [WIDTH-1:0] par_out,
  output logic             scan_out
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] q_next;
  logic             fb;
  bilbo_mode_e      mode_e;

  assign mode_e = bilbo_mode_e'(mode);

  bilbo_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
    .state (q),
    .fb    (fb)
  );

  bilbo_next_state #(.WIDTH(WIDTH), .SEED(SEED)) u_ns (
    .mode       (mode_e),
    .state      (q),
    .fb         (fb),
    .par_in     (par_in),
    .scan_in    (scan_in),
    .next_state (q_next)
  );

  always_ff @(posedge clk) begin
    if (rst)            q <= '0;
    else if (seed_load) q <= SEED;
    else                q <= q_next;
  end

  assign par_out  = q;
  assign scan_out = q[MSB];

endmodule

// File: rtl/bilbo_reg_checker.sv
module bilbo_reg_checker #(
  parameter int               WIDTH = 8,
  parameter logic [WIDTH-1:0] SEED  = 8'h01
) (
  input logic             clk,
  input logic             rst,
  input logic             seed_load,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] par_in,
  input logic             scan_in,
  input logic [WIDTH-1:0] par_out,
  input logic             scan_out
);

  logic active;
  assign active = !rst && !seed_load;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> par_out == '0); // R1

  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> par_out == SEED); // R2

  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (active && mode == 2'b00) |=> par_out == $past(par_in)); // R3

  AST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (active && mode == 2'b01) |=>
      par_out == {$past(par_out[WIDTH-2:0]), $past(scan_in)}); // R4

  AST_GEN_SHIFTS: assert property (@(posedge clk) disable iff (rst)
    (active && mode == 2'b10 && par_out != '0) |=>
      (par_out[WIDTH-1:1] == $past(par_out[WIDTH-2:0]) && par_out != '0)); // R6

  AST_GEN_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    (active && mode == 2'b10 && par_out == '0) |=> par_out == SEED); // R8

  AST_COMPACT_FOLD: assert property (@(posedge clk) disable iff (rst)
    (active && mode == 2'b11) |=>
      ((par_out ^ $past(par_in)) >> 1) == {1'b0, $past(par_out[WIDTH-2:0])}); // R9

endmodule

bind bilbo_reg bilbo_reg_checker #(.WIDTH(WIDTH), .SEED(SEED)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .seed_load (seed_load),
  .mode      (mode),
  .par_in    (par_in),
  .scan_in   (scan_in),
  .par_out   (par_out),
  .scan_out  (scan_out)
);

// File: tb/bilbo_reg_bench.sv
module bilbo_reg_bench;

  localparam logic [7:0] BENCH_SEED = 8'hA5;
  localparam int NVEC = 16;
  // {seed_load, mode[1:0], par_in[7:0], scan_in}
  localparam logic [11:0] VEC [NVEC] = '{
    {1'b0, 2'b00, 8'h3C, 1'b0}, {1'b0, 2'b00, 8'hC3, 1'b1},
    {1'b0, 2'b01, 8'hFF, 1'b1}, {1'b0, 2'b01, 8'h00, 1'b0},
    {1'b0, 2'b01, 8'h55, 1'b1}, {1'b0, 2'b10, 8'hAA, 1'b0},
    {1'b0, 2'b10, 8'h00, 1'b1}, {1'b0, 2'b11, 8'h12, 1'b0},
    {1'b0, 2'b11, 8'h80, 1'b1}, {1'b1, 2'b11, 8'hFF, 1'b1},
    {1'b0, 2'b10, 8'h00, 1'b0}, {1'b0, 2'b10, 8'h0F, 1'b0},
    {1'b1, 2'b00, 8'h77, 1'b0}, {1'b0, 2'b11, 8'h01, 1'b0},
    {1'b0, 2'b01, 8'h00, 1'b1}, {1'b0, 2'b00, 8'h00, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       seed_load = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] par_in = 8'h00;
  logic       scan_in = 1'b0;
  logic [7:0] par_out;
  logic       scan_out;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] exp_q = 8'h00;

  bilbo_reg #(.WIDTH(8), .TAPS(8'b1011_1000), .SEED(BENCH_SEED)) u_bilbo_reg (
    .clk(clk), .rst(rst), .seed_load(seed_load), .mode(mode),
    .par_in(par_in), .scan_in(scan_in), .par_out(par_out), .scan_out(scan_out)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] model(input logic [7:0] q, input logic r,
      input logic sl, input logic [1:0] m, input logic [7:0] d, input logic si);
    logic f;
    f = q[7] ^ q[5] ^ q[4] ^ q[3];
    if (r) return 8'h00;
    if (sl) return BENCH_SEED;
    case (m)
      2'b00: return d;
      2'b01: return {q[6:0], si};
      2'b10: return (q == 8'h00) ? BENCH_SEED : {q[6:0], f};
      default: return {q[6:0], f} ^ d;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic r, input logic sl, input logic [1:0] m,
                      input logic [7:0] d, input logic si);
    rst = r; seed_load = sl; mode = m; par_in = d; scan_in = si;
    exp_q = model(exp_q, r, sl, m, d, si);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] sig_a, sig_b, unloaded;
    int first_ret;
    bit zero_seen;

    @(negedge clk);
    @(negedge clk);
    chk("R1 reset state", par_out, 8'h00);
    chk("R5 scan_out after reset", {7'd0, scan_out}, 8'h00);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      step(1'b0, VEC[i][11], VEC[i][10:9], VEC[i][8:1], VEC[i][0]);
      chk($sformatf("R2/R3/R4/R6/R9 vector %0d", i), par_out, exp_q);
      chk($sformatf("R5 scan_out vector %0d", i), {7'd0, scan_out}, {7'd0, exp_q[7]});
    end

    // R2: seed load overrides compaction with busy inputs
    step(1'b0, 1'b1, 2'b11, 8'hFF, 1'b1);
    chk("R2 seed load in compact mode", par_out, BENCH_SEED);

    // R6/R7: full generator period
    first_ret = 0;
    zero_seen = 1'b0;
    for (int k = 1; k <= 255; k++) begin
      step(1'b0, 1'b0, 2'b10, 8'h00, 1'b0);
      if (k == 1) chk("R6 first generate step", par_out, 8'h4A);
      if (par_out == 8'h00) zero_seen = 1'b1;
      if (par_out == BENCH_SEED && first_ret == 0) first_ret = k;
    end
    chk("R7 period", first_ret[7:0], 8'd255);
    chk("R7 no zero state", {7'd0, zero_seen}, 8'h00);

    // R1 mid-run reset, then R8 lock-up escape
    step(1'b1, 1'b1, 2'b10, 8'h00, 1'b0);
    chk("R1 reset beats seed_load", par_out, 8'h00);
    step(1'b0, 1'b0, 2'b10, 8'h00, 1'b0);
    chk("R8 zero state reloads seed", par_out, BENCH_SEED);

    // R10: signatures
    step(1'b0, 1'b1, 2'b00, 8'h00, 1'b0);
    for (int k = 0; k < 8; k++) step(1'b0, 1'b0, 2'b11, 8'(k * 37 + 3), 1'b0);
    chk("R9 compaction signature A", par_out, exp_q);
    sig_a = par_out;
    step(1'b0, 1'b1, 2'b00, 8'h00, 1'b0);
    for (int k = 0; k < 8; k++) step(1'b0, 1'b0, 2'b11, 8'(k * 37 + 3), 1'b0);
    chk("R10 repeatable signature", par_out, sig_a);
    step(1'b0, 1'b1, 2'b00, 8'h00, 1'b0);
    for (int k = 0; k < 8; k++)
      step(1'b0, 1'b0, 2'b11, 8'(k * 37 + 3) ^ ((k == 2) ? 8'h10 : 8'h00), 1'b0);
    sig_b = par_out;
    chk("R9 compaction signature B", sig_b, exp_q);
    checks++;
    if (sig_a == sig_b) begin
      fails++;
      $display("FAIL R10 signatures equal: actual=%h expected!=%h", sig_b, sig_a);
    end

    // R5: serial unload of signature B, most significant bit first
    unloaded = 8'h00;
    for (int k = 0; k < 8; k++) begin
      unloaded = {unloaded[6:0], scan_out};
      step(1'b0, 1'b0, 2'b01, 8'h00, 1'b0);
    end
    chk("R5 serial unload of signature", unloaded, sig_b);
    chk("R4 chain empty after unload", par_out, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule